// File: doc/BRIEF.md
# Queued SPI Master

This block is an SPI master that runs a short list of transfers without any help from the host once the list is started. The host fills up to sixteen queue entries. Each entry has a transmit word, a command word and a slot for the word it receives. The host then sets a start bit. The sequencer walks the entries from index 0 up to a programmed last index. For each entry it shifts a word out on MOSI while it samples MISO. It drives up to four chip-select lines as each entry's command asks. When the last entry is done it raises a completion flag and an interrupt line.

All host access goes through a small register bus with a select code. The registers hold the serial format (half-period divisor, clock polarity, clock phase, programmable word width, master enable), the queue end index and the chip-select idle level, the inter-transfer pause length with the start bit, and the completion flag. A pointer register and a data port reach the three queue memories. The pointer picks a memory region and an entry, and it steps forward by one after each data-port access. A host that needs more than sixteen words splits the job into successive runs.

Top module: `qspi_queue_master`

## Requirements
- R1: After reset, sck is 0, cs is 4'hF, irq is 0, and the registers at select codes 0 (format), 2 (control) and 3 (status) read 0. Select code 1 (queue limits) reads 16'h0100, which means idle level 1 and end index 0.
- R2: The pointer is at select code 4, bits [5:0]. Bits [5:4] pick a region: 0 is transmit, 1 is receive, 2 is command, 3 is unused. Bits [3:0] pick the entry. Each read or write of the data port (select code 5) uses the pointed entry and then adds one to the pointer. A write to the receive region or to region 3 changes no stored word.
- R3: The format register holds the divisor in bits [7:0]. Each SCK half period lasts that many system clocks, and a value below 2 counts as 2. SCK rests at the polarity bit (bit 13) whenever no word is being shifted.
- R4: Words go out MSB first. The width is the format field [11:8] (0 means 16) when command bit 14 is set, and 8 otherwise. With the phase bit (bit 12) clear, the slave samples on the leading SCK edge. With it set, the slave samples on the trailing edge.
- R5: The word sampled from MISO for entry k is stored at receive entry k, right-aligned.
- R6: One run executes entries 0 through the end index, which is field [3:0] of the queue-limits register, so a run has end index + 1 words and 2 × width SCK edges per word.
- R7: While entry k runs, each chip select whose bit is set in command bits [3:0] sits at the inverse of the idle level. All other chip selects, and all chip selects outside a run, sit at the idle level, which is bit 8 of the queue-limits register.
- R8: With command bit 15 set, the chip selects stay active into the next entry. With it clear, they return to idle between entries, so each entry gets its own select pulse.
- R9: From the last SCK edge of one entry to the first SCK edge of the next takes divisor + 2 clocks. One more clock is added when command bit 15 is clear. When command bit 13 is set, pause + 1 more clocks are added, where the pause is control bits [7:0].
- R10: Writing control bit 15 with format bit 15 (master) set starts a run. Bit 15 reads 1 during the run and clears itself at the end. With the master bit clear, the write starts nothing.
- R11: Status bit 0 sets when the last entry completes, and irq follows it. Writing 1 to that bit clears it. Writing 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 3 | Register select code |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (steps the pointer on the data port) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | 4 | Chip selects |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong sequencer state shows up first on the chip selects and on the gap between words. A missed or extra state moves the first SCK edge of the next entry by whole clocks, so the bench checks that gap against the exact count in R9 and counts select pulses for each run. A fault in the shift engine shows within the same word: a wrong edge count, a misplaced sampling edge or a bad alignment produces a wrong word at the bench's model slave or in the receive memory after that run. Pointer or region faults show on the next data-port read.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

  localparam int BUS_W = 16;

  // register select codes
  localparam logic [2:0] RS_MODE = 3'd0;
  localparam logic [2:0] RS_WRAP = 3'd1;
  localparam logic [2:0] RS_CTRL = 3'd2;
  localparam logic [2:0] RS_STAT = 3'd3;
  localparam logic [2:0] RS_PTR  = 3'd4;
  localparam logic [2:0] RS_DATA = 3'd5;

  // command word bit positions
  localparam int CMD_HOLD  = 15;
  localparam int CMD_WIDE  = 14;
  localparam int CMD_PAUSE = 13;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_XFER,
    SQ_GAP,
    SQ_DESEL
  } seq_state_t;

  // clocks per SCK half period; values below 2 behave as 2
  function automatic logic [7:0] half_period(input logic [7:0] div);
    return (div < 8'd2) ? 8'd2 : div;
  endfunction

  // word width in bits for one entry
  function automatic logic [4:0] word_bits(input logic [3:0] field, input logic wide);
    if (!wide) return 5'd8;
    return (field == 4'd0) ? 5'd16 : {1'b0, field};
  endfunction

endpackage

// File: rtl/qspi_ram.sv
module qspi_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr_a,
  output logic [DW-1:0]            rdata_a,
  input  logic [$clog2(DEPTH)-1:0] raddr_b,
  output logic [DW-1:0]            rdata_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/qspi_shift_engine.sv
module qspi_shift_engine #(
  parameter int DW   = 16,
  parameter int DIVW = 8,
  localparam int NBW = $clog2(DW) + 1,
  localparam int EW  = NBW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DW-1:0]   tx_word,
  input  logic [NBW-1:0]  nbits,
  input  logic [DIVW-1:0] div,
  input  logic            cpol,
  input  logic            cpha,
  input  logic            miso,
  output logic            sck,
  output logic            mosi,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   rx_word
);
  localparam logic [NBW-1:0] DWL = NBW'(DW);

  logic            active;
  logic [DIVW-1:0] hc;
  logic [EW-1:0]   ec;
  logic            tog;
  logic [DW-1:0]   tx_sr, rx_sr;
  logic [NBW-1:0]  nb_q;
  logic [DIVW-1:0] div_q;
  logic            cpha_q;
  logic            done_q;

  // named edge events
  logic edge_now, lead_edge, sample_now, shift_now, last_now;
  assign edge_now   = active && (hc == div_q - 1'b1);
  assign lead_edge  = ~ec[0];
  assign sample_now = edge_now && (lead_edge ^ cpha_q);
  assign shift_now  = edge_now && !(lead_edge ^ cpha_q) && (ec != '0);
  assign last_now   = edge_now && (ec == EW'({nb_q, 1'b0} - 1'b1));

  function automatic logic [DW-1:0] align_msb(input logic [DW-1:0] w, input logic [NBW-1:0] n);
    return w << (DWL - n);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      hc     <= '0;
      ec     <= '0;
      tog    <= 1'b0;
      tx_sr  <= '0;
      rx_sr  <= '0;
      nb_q   <= '0;
      div_q  <= '0;
      cpha_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_now;
      if (start && !active) begin
        active <= 1'b1;
        hc     <= '0;
        ec     <= '0;
        tog    <= 1'b0;
        tx_sr  <= align_msb(tx_word, nbits);
        rx_sr  <= '0;
        nb_q   <= nbits;
        div_q  <= div;
        cpha_q <= cpha;
      end else if (active) begin
        hc <= edge_now ? '0 : hc + 1'b1;
        if (edge_now) begin
          tog <= ~tog;
          ec  <= ec + 1'b1;
        end
        if (sample_now) rx_sr <= {rx_sr[DW-2:0], miso};
        if (shift_now)  tx_sr <= {tx_sr[DW-2:0], 1'b0};
        if (last_now)   active <= 1'b0;
      end
    end
  end

  assign sck     = cpol ^ tog;
  assign mosi    = tx_sr[DW-1];
  assign busy    = active;
  assign done    = done_q;
  assign rx_word = rx_sr;

  assert_half_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (hc < div_q));
  assert_sck_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (tog == 1'b0));
  assert_edge_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (ec < {nb_q, 1'b0}));
endmodule

// File: rtl/qspi_queue_master.sv
module qspi_queue_master
  import qspi_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int NCS   = 4,
  parameter int DIVW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     bus_sel,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [15:0]    bus_wdata,
  output logic [15:0]    bus_rdata,
  output logic           sck,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs,
  output logic           irq
);
  localparam int IW  = $clog2(DEPTH);
  localparam int PW  = IW + 2;
  localparam int NBW = $clog2(DW) + 1;

  // ---------------- host registers ----------------
  logic [15:0]   mode_q;
  logic [IW-1:0] end_q;
  logic          idle_q;
  logic [7:0]    dly_q;
  logic          busy_q;
  logic          done_flag;
  logic [PW-1:0] ptr_q;

  logic [DIVW-1:0] f_div;
  logic [3:0]      f_bits;
  logic            f_cpha, f_cpol, f_master;
  assign f_div    = mode_q[DIVW-1:0];
  assign f_bits   = mode_q[11:8];
  assign f_cpha   = mode_q[12];
  assign f_cpol   = mode_q[13];
  assign f_master = mode_q[15];

  logic wr_mode, wr_wrap, wr_ctrl, wr_stat, wr_ptr, dp_wr, dp_rd, dp_access;
  assign wr_mode   = bus_wr && (bus_sel == RS_MODE);
  assign wr_wrap   = bus_wr && (bus_sel == RS_WRAP);
  assign wr_ctrl   = bus_wr && (bus_sel == RS_CTRL);
  assign wr_stat   = bus_wr && (bus_sel == RS_STAT);
  assign wr_ptr    = bus_wr && (bus_sel == RS_PTR);
  assign dp_wr     = bus_wr && (bus_sel == RS_DATA);
  assign dp_rd     = bus_rd && (bus_sel == RS_DATA);
  assign dp_access = dp_wr || dp_rd;

  logic [1:0]    region;
  logic [IW-1:0] h_idx;
  assign region = ptr_q[PW-1:IW];
  assign h_idx  = ptr_q[IW-1:0];

  // ---------------- sequencer state ----------------
  seq_state_t    st;
  logic [IW-1:0] q_idx;
  logic [7:0]    gap_cnt;

  logic [DW-1:0]    tx_h, tx_e, rx_h, rx_e, rx_word;
  logic [BUS_W-1:0] cmd_h, cmd_e;
  logic             eng_start, eng_busy, eng_done;

  logic go, at_end, step_done, q_finish, rx_store, cs_on;
  logic cur_hold, cur_pause, cur_wide;
  logic [NCS-1:0] cur_mask;

  assign cur_hold  = cmd_e[CMD_HOLD];
  assign cur_wide  = cmd_e[CMD_WIDE];
  assign cur_pause = cmd_e[CMD_PAUSE];
  assign cur_mask  = cmd_e[NCS-1:0];

  assign go        = wr_ctrl && bus_wdata[15] && f_master && (st == SQ_IDLE);
  assign at_end    = (q_idx == end_q);
  assign step_done = ((st == SQ_XFER) && eng_done && !cur_pause) ||
                     ((st == SQ_GAP) && (gap_cnt == 8'd0));
  assign q_finish  = step_done && at_end;
  assign rx_store  = (st == SQ_XFER) && eng_done;
  assign eng_start = (st == SQ_SETUP);
  assign cs_on     = (st == SQ_SETUP) || (st == SQ_XFER) ||
                     ((st == SQ_GAP) && cur_hold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      end_q     <= '0;
      idle_q    <= 1'b1;
      dly_q     <= '0;
      busy_q    <= 1'b0;
      done_flag <= 1'b0;
      ptr_q     <= '0;
    end else begin
      if (wr_mode) mode_q <= bus_wdata;
      if (wr_wrap) begin
        end_q  <= bus_wdata[IW-1:0];
        idle_q <= bus_wdata[8];
      end
      if (wr_ctrl) dly_q <= bus_wdata[7:0];
      if (q_finish)  busy_q <= 1'b0;
      else if (go)   busy_q <= 1'b1;
      if (q_finish)                     done_flag <= 1'b1;
      else if (wr_stat && bus_wdata[0]) done_flag <= 1'b0;
      if (wr_ptr)         ptr_q <= bus_wdata[PW-1:0];
      else if (dp_access) ptr_q <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      q_idx   <= '0;
      gap_cnt <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (go) begin
          st    <= SQ_SETUP;
          q_idx <= '0;
        end
        SQ_SETUP: st <= SQ_XFER;
        SQ_XFER: if (eng_done && cur_pause) begin
          st      <= SQ_GAP;
          gap_cnt <= dly_q;
        end
        SQ_GAP: if (gap_cnt != 8'd0) gap_cnt <= gap_cnt - 1'b1;
        SQ_DESEL: st <= SQ_SETUP;
        default: st <= SQ_IDLE;
      endcase
      if (step_done) begin
        if (at_end) begin
          st <= SQ_IDLE;
        end else begin
          q_idx <= q_idx + 1'b1;
          st    <= cur_hold ? SQ_SETUP : SQ_DESEL;
        end
      end
    end
  end

  // ---------------- queue memories ----------------
  qspi_ram #(.DW(DW), .DEPTH(DEPTH)) u_tx_ram (
    .clk(clk), .rst_n(rst_n),
    .we(dp_wr && (region == 2'd0)), .waddr(h_idx), .wdata(bus_wdata[DW-1:0]),
    .raddr_a(h_idx), .rdata_a(tx_h), .raddr_b(q_idx), .rdata_b(tx_e)
  );

  qspi_ram #(.DW(DW), .DEPTH(DEPTH)) u_rx_ram (
    .clk(clk), .rst_n(rst_n),
    .we(rx_store), .waddr(q_idx), .wdata(rx_word),
    .raddr_a(h_idx), .rdata_a(rx_h), .raddr_b(q_idx), .rdata_b(rx_e)
  );

  qspi_ram #(.DW(BUS_W), .DEPTH(DEPTH)) u_cmd_ram (
    .clk(clk), .rst_n(rst_n),
    .we(dp_wr && (region == 2'd2)), .waddr(h_idx), .wdata(bus_wdata),
    .raddr_a(h_idx), .rdata_a(cmd_h), .raddr_b(q_idx), .rdata_b(cmd_e)
  );

  // ---------------- serial engine ----------------
  qspi_shift_engine #(.DW(DW), .DIVW(DIVW)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .start(eng_start), .tx_word(tx_e),
    .nbits(NBW'(word_bits(f_bits, cur_wide))),
    .div(DIVW'(half_period(8'(f_div)))),
    .cpol(f_cpol), .cpha(f_cpha), .miso(miso),
    .sck(sck), .mosi(mosi), .busy(eng_busy), .done(eng_done), .rx_word(rx_word)
  );

  // ---------------- chip selects ----------------
  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs[i] = (cs_on && cur_mask[i]) ? ~idle_q : idle_q;
  end

  assign irq = done_flag;

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    case (bus_sel)
      RS_MODE: bus_rdata = mode_q;
      RS_WRAP: bus_rdata = {7'd0, idle_q, 4'd0, 4'(end_q)};
      RS_CTRL: bus_rdata = {busy_q, 7'd0, dly_q};
      RS_STAT: bus_rdata = {15'd0, done_flag};
      RS_PTR:  bus_rdata = 16'(ptr_q);
      RS_DATA: begin
        case (region)
          2'd0:    bus_rdata = 16'(tx_h);
          2'd1:    bus_rdata = 16'(rx_h);
          2'd2:    bus_rdata = cmd_h;
          default: bus_rdata = '0;
        endcase
      end
      default: bus_rdata = '0;
    endcase
  end

  assert_cs_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (cs == {NCS{idle_q}}));
  assert_done_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(q_finish));
  assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(q_finish));
  assert_start_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !eng_busy);
  assert_rx_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_store |-> busy_q);
endmodule

// File: tb/test_qspi_queue_master.sv
module test_qspi_queue_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_sel = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        sck, mosi, irq;
  logic        miso;
  logic [3:0]  cs;

  always #10 clk = ~clk;  // 50 MHz

  qspi_queue_master i_qspi_queue_master (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .cs(cs), .irq(irq)
  );

  int n_checks = 0;
  int n_err = 0;
  bit finished = 0;

  // slave model configuration (written by tasks only)
  int  run_id = 0;
  int  m_n = 8;
  bit  m_cpol = 0, m_cpha = 0, m_idle = 1;
  bit  mon_clear = 0;

  // slave model state (written by the monitor only)
  int  cyc = 0;
  int  g_bits, c_bits, edges, t_last, t_half, t_gap, cs_cnt, cs_bad;
  logic [15:0] acc;
  logic [15:0] cap [16];
  logic prev_sck, prev_act;

  function automatic logic [15:0] tx_of(int r, int k);
    return 16'hC3A5 ^ (16'(k) * 16'h2B4D) ^ (16'(r) << 3);
  endfunction

  function automatic logic [15:0] sl_of(int r, int k);
    return 16'h5A3C ^ (16'(k) * 16'h1357) ^ (16'(r) * 16'h0101);
  endfunction

  function automatic logic [15:0] mask_of(int n);
    return (n >= 16) ? 16'hFFFF : 16'((32'h1 << n) - 1);
  endfunction

  function automatic logic sbit(int gi);
    int k = gi / m_n;
    int b = m_n - 1 - (gi % m_n);
    logic [15:0] w = sl_of(run_id, k);
    return w[b];
  endfunction

  function automatic logic [3:0] cs_exp(int k);
    logic [3:0] m = 4'b0001 << (k % 4);
    return m_idle ? ~m : m;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // bench model of an SPI slave, observed away from the active edge
  always @(negedge clk) begin
    if (mon_clear) begin
      g_bits = 0; c_bits = 0; edges = 0; t_last = 0; t_half = -1; t_gap = -1;
      cs_cnt = 0; cs_bad = 0; acc = '0;
      prev_sck = sck; prev_act = 1'b0;
      miso = m_cpha ? 1'b0 : sbit(0);
    end else begin
      if (sck !== prev_sck) begin
        logic lead, samp;
        lead = (prev_sck == m_cpol);
        samp = lead ^ m_cpha;
        if (edges == 1) t_half = cyc - t_last;
        if (edges == 2 * m_n) t_gap = cyc - t_last;
        t_last = cyc;
        edges++;
        if (samp) begin
          acc = {acc[14:0], mosi};
          if (cs !== cs_exp(c_bits / m_n)) cs_bad++;
          c_bits++;
          if ((c_bits % m_n) == 0 && (c_bits / m_n) <= 16)
            cap[c_bits / m_n - 1] = acc & mask_of(m_n);
        end else if (!m_cpha) begin
          g_bits++;
          miso = sbit(g_bits);
        end else begin
          miso = sbit(g_bits);
          g_bits++;
        end
      end
      if ((cs !== {4{m_idle}}) && !prev_act) cs_cnt++;
      prev_act = (cs !== {4{m_idle}});
      prev_sck = sck;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic br(input logic [2:0] s, output logic [15:0] d);
    @(negedge clk);
    bus_sel = s; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    logic [15:0] v;
    int t = 0;
    do begin
      br(3'd3, v);
      t++;
    end while (!v[0] && t < 20000);
    ok = v[0];
  endtask

  task automatic run_q(input int nent, input int div, input int bfield, input bit wide,
                       input bit cpol, input bit cpha, input bit hold, input bit pause,
                       input int dly, input bit idle);
    int width, effd, gap;
    bit ok;
    logic [15:0] v;
    run_id++;
    width = wide ? ((bfield == 0) ? 16 : bfield) : 8;
    effd  = (div < 2) ? 2 : div;
    m_n = width; m_cpol = cpol; m_cpha = cpha; m_idle = idle;
    bw(3'd0, {1'b1, 1'b0, cpol, cpha, 4'(bfield), 8'(div)});
    bw(3'd1, {7'd0, idle, 4'd0, 4'(nent - 1)});
    bw(3'd2, 16'(dly));
    bw(3'd4, 16'h0000);
    for (int k = 0; k < nent; k++) bw(3'd5, tx_of(run_id, k));
    bw(3'd4, 16'h0020);
    for (int k = 0; k < nent; k++)
      bw(3'd5, {hold, wide, pause, 9'd0, 4'b0001 << (k % 4)});
    bw(3'd3, 16'h0001);
    @(negedge clk); #2 mon_clear = 1'b1;
    @(negedge clk); #2 mon_clear = 1'b0;
    bw(3'd2, 16'h8000 | 16'(dly));
    wait_done(ok);
    chk("R11 done flag set", 32'(ok), 1);
    chk("R11 irq follows flag", 32'(irq), 1);
    br(3'd2, v);
    chk("R10 start bit self-clears", 32'(v[15]), 0);
    chk("R3 sck rests at polarity", 32'(sck), 32'(cpol));
    chk("R6 edge count", 32'(edges), 32'(2 * nent * width));
    chk("R3 half period", 32'(t_half), 32'(effd));
    if (nent >= 2) begin
      gap = effd + 2 + (hold ? 0 : 1) + (pause ? dly + 1 : 0);
      chk("R9 inter-entry gap", 32'(t_gap), 32'(gap));
    end
    chk("R7 chip-select pattern", 32'(cs_bad), 0);
    chk("R8 select pulses", 32'(cs_cnt), hold ? 1 : 32'(nent));
    for (int k = 0; k < nent; k++)
      chk("R4 word seen by slave", 32'(cap[k]), 32'(tx_of(run_id, k) & mask_of(width)));
    bw(3'd4, 16'h0010);
    for (int k = 0; k < nent; k++) begin
      br(3'd5, v);
      chk("R5 receive entry", 32'(v), 32'(sl_of(run_id, k) & mask_of(width)));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++; n_checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int divs [4] = '{1, 2, 3, 5};
    int bfs  [4] = '{5, 12, 11, 0};
    miso = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sck", 32'(sck), 0);
    chk("R1 cs", 32'(cs), 32'hF);
    chk("R1 irq", 32'(irq), 0);
    br(3'd0, v); chk("R1 format reg", 32'(v), 0);
    br(3'd1, v); chk("R1 limits reg", 32'(v), 32'h0100);
    br(3'd2, v); chk("R1 control reg", 32'(v), 0);
    br(3'd3, v); chk("R1 status reg", 32'(v), 0);

    // R2 pointer and data port
    bw(3'd4, 16'h0000);
    for (int k = 0; k < 3; k++) bw(3'd5, 16'h1111 * 16'(k + 1));
    br(3'd4, v); chk("R2 pointer steps on write", 32'(v), 3);
    bw(3'd4, 16'h0000);
    for (int k = 0; k < 3; k++) begin
      br(3'd5, v); chk("R2 transmit readback", 32'(v), 32'(16'h1111 * 16'(k + 1)));
    end
    br(3'd4, v); chk("R2 pointer steps on read", 32'(v), 3);
    bw(3'd4, 16'h002E);
    bw(3'd5, 16'hA001); bw(3'd5, 16'hB002); bw(3'd5, 16'hC003);
    br(3'd4, v); chk("R2 pointer into region 3", 32'(v), 32'h31);
    bw(3'd4, 16'h002E);
    br(3'd5, v); chk("R2 command entry 14", 32'(v), 32'hA001);
    br(3'd5, v); chk("R2 command entry 15", 32'(v), 32'hB002);
    br(3'd5, v); chk("R2 region 3 reads zero", 32'(v), 0);

    // R10 start ignored without master bit
    bw(3'd0, 16'h0002);
    bw(3'd1, 16'h0100);
    bw(3'd2, 16'h8000);
    repeat (40) @(negedge clk);
    br(3'd2, v); chk("R10 no start when not master", 32'(v[15]), 0);
    chk("R10 sck stays idle", 32'(sck), 0);
    br(3'd3, v); chk("R10 no completion", 32'(v), 0);

    // sweep over modes, divisors, widths and command options
    for (int m = 0; m < 4; m++) begin
      for (int di = 0; di < 4; di++) begin
        run_q(2 + di, divs[di], bfs[di], di != 1, m[1], m[0],
              ((m + di) % 2) == 1, (di == 2) || (m == 3), m, m != 2);
        if (m == 0 && di == 0) begin
          bw(3'd3, 16'h0000);
          br(3'd3, v); chk("R11 writing 0 keeps flag", 32'(v[0]), 1);
          bw(3'd3, 16'h0001);
          br(3'd3, v); chk("R11 writing 1 clears flag", 32'(v[0]), 0);
          chk("R11 irq cleared", 32'(irq), 0);
        end
      end
    end

    // full sixteen-entry queue at 16 bits
    run_q(16, 2, 0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 0, 1'b1);

    // R2 host write into receive region has no effect
    bw(3'd4, 16'h0010);
    bw(3'd5, 16'hFFFF);
    bw(3'd4, 16'h0010);
    br(3'd5, v);
    chk("R2 receive region not host-writable", 32'(v), 32'(sl_of(run_id, 0)));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule